// File: doc/BRIEF.md
# I2C Byte-Memory Write Target

This block is a bus target that takes write transactions from an I2C controller and stores them in a small on-chip byte memory. It oversamples the SCL and SDA pins on the system clock and recognises Start and Stop. It answers only to its own 7-bit select code with the direction bit cleared. After the select byte it takes a 16-bit byte address, high byte first. The data bytes that follow are staged in a four-byte row buffer. They reach the memory only when the controller ends the transaction with a Stop placed right after an acknowledge.

A commit starts a timed internal write cycle. For that whole cycle the block flags itself busy, releases SDA and ignores the bus. Two status inputs gate data acceptance: a write-lock flag and a password-granted flag. While the lock is set and no password has been granted, every data byte is refused and nothing is stored. Other logic on the chip can read the stored bytes through a combinational side port. It can also read the address that follows the last byte written.

Top module: `i2c_wr_target`

## Requirements
- R1: After reset, SDA is released, busy is low, the next-address output is 0 and every memory byte reads 0.
- R2: A select byte equal to {DEV_ADDR, 0} is acknowledged: SDA is pulled low during the ninth clock. Any other select byte, including one with the direction bit set, gets a NoAck, and the bus is ignored until the next Start.
- R3: The two bytes after an accepted select byte are acknowledged and form a 16-bit address, high byte first. Memory byte index = address bits MEM_AW-1..0, where bits 1..0 are the column inside a four-byte row.
- R4: With lock low, or with the password granted, every data byte is acknowledged.
- R5: With lock high and password not granted, every data byte gets a NoAck, the memory is unchanged and no write cycle starts.
- R6: Data bytes fill the row of the given address, starting at column address[1:0]. The column increments and wraps from 3 to 0, so later bytes overwrite earlier ones.
- R7: The memory is written only when a Stop falls in the first bit slot after the acknowledge of an accepted data byte. A Stop at any other point, or with no accepted data, discards the staged bytes.
- R8: A commit raises busy for exactly WCYC system clocks.
- R9: While busy is high, SDA is never pulled and Start or select traffic is ignored. A transaction begun during busy stays ignored up to its Stop.
- R10: After a commit, the next-address output holds the 16-bit address of the last byte written, plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| sda_pull_o | output | 1 | 1 drives SDA low (open drain) |
| lock_i | input | 1 | Write lock flag |
| pwd_ok_i | input | 1 | Password granted flag |
| busy_o | output | 1 | Internal write cycle in progress |
| next_addr_o | output | 16 | Address following the last byte written |
| peek_addr_i | input | MEM_AW | Side read address |
| peek_data_o | output | 8 | Byte at peek_addr_i |

## Verification
The assertions assume that the lock and password flags stay fixed for the whole of a transaction. They also assume that the controller changes SDA only while SCL is low, except when it forms a Start or Stop. The bench changes the two flags only between transactions. It moves SDA a quarter bit period after each SCL fall, and every SCL phase lasts several system clocks, so each edge passes through the synchroniser cleanly. Stops are placed on purpose in the tenth slot, in the middle of a byte, or right after the address bytes, to exercise the commit rule.

// File: rtl/i2c_wr_pkg.sv
// Shared types for the I2C write target.
// Assumes: rows hold four bytes, so a column is two bits wide.
package i2c_wr_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEL,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } phase_t;

    localparam int COL_W   = 2;
    localparam int ROW_LEN = 1 << COL_W;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises SCL and SDA into the system clock domain and reports
// SCL edges and bus Start/Stop as one-cycle pulses.
// Assumes: each SCL phase spans several system clocks.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [1:0] pipe [STAGES+1];
    logic [1:0] prev;

    assign pipe[0] = {scl_i, sda_i};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // one synchroniser stage for both lines; idle bus level is high
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g+1] <= 2'b11;
            else        pipe[g+1] <= pipe[g];
        end
    end

    // previous synchronised sample, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 2'b11;
        else        prev <= pipe[STAGES];
    end

    assign scl_s    = pipe[STAGES][1];
    assign sda_s    = pipe[STAGES][0];
    assign scl_rise = scl_s & ~prev[1];
    assign scl_fall = ~scl_s & prev[1];
    assign start_p  = scl_s & prev[1] & prev[0] & ~sda_s;
    assign stop_p   = scl_s & prev[1] & ~prev[0] & sda_s;
endmodule

// File: rtl/i2c_wr_fsm.sv
// Bit and byte engine: shifts in bytes on SCL rises, decides acknowledges,
// stages up to four data bytes in a row buffer and raises commit when a
// Stop lands in the slot after an acknowledge.
// Assumes: lock and pwd are stable over a transaction.
module i2c_wr_fsm
    import i2c_wr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h53
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_s,
    input  logic                     sda_s,
    input  logic                     scl_rise,
    input  logic                     scl_fall,
    input  logic                     start_p,
    input  logic                     stop_p,
    input  logic                     busy,
    input  logic                     lock,
    input  logic                     pwd,
    output logic                     sda_pull,
    output logic                     commit,
    output logic [13:0]              row_o,
    output logic [COL_W-1:0]         col_o,
    output logic [ROW_LEN*8-1:0]     data_o,
    output logic [ROW_LEN-1:0]       vld_o
);
    phase_t     ph;
    logic [3:0] bit_cnt;
    logic [6:0] shreg;
    logic       ack_q;
    logic       data_slot;
    logic [7:0] byte_in;
    logic       wr_ok;
    logic       ack_now;

    assign byte_in = {shreg, sda_s};
    assign wr_ok   = !lock || pwd;

    // acknowledge decision for the byte completing on this SCL rise
    always_comb begin
        case (ph)
            PH_SEL:         ack_now = (byte_in[7:1] == DEV_ADDR) && !byte_in[0];
            PH_AHI, PH_ALO: ack_now = 1'b1;
            PH_DATA:        ack_now = wr_ok;
            default:        ack_now = 1'b0;
        endcase
    end

    // transaction sequencing, byte capture, ack drive and commit decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            ack_q     <= 1'b0;
            data_slot <= 1'b0;
            sda_pull  <= 1'b0;
            commit    <= 1'b0;
            row_o     <= '0;
            col_o     <= '0;
            data_o    <= '0;
            vld_o     <= '0;
        end else begin
            commit <= 1'b0;
            if (busy) begin
                ph        <= PH_IDLE;
                bit_cnt   <= '0;
                sda_pull  <= 1'b0;
                data_slot <= 1'b0;
            end else if (start_p) begin
                ph        <= PH_SEL;
                bit_cnt   <= '0;
                vld_o     <= '0;
                sda_pull  <= 1'b0;
                data_slot <= 1'b0;
            end else if (stop_p) begin
                commit    <= (ph == PH_DATA) && (bit_cnt == 4'd1) && (vld_o != '0);
                ph        <= PH_IDLE;
                sda_pull  <= 1'b0;
                data_slot <= 1'b0;
            end else if (ph != PH_IDLE) begin
                if (scl_rise) begin
                    if (bit_cnt < 4'd7) begin
                        shreg   <= byte_in[6:0];
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (bit_cnt == 4'd7) begin
                        bit_cnt   <= 4'd8;
                        ack_q     <= ack_now;
                        data_slot <= (ph == PH_DATA);
                        case (ph)
                            PH_SEL: if (!ack_now) ph <= PH_IDLE;
                                    else          ph <= PH_AHI;
                            PH_AHI: begin
                                row_o[13:6] <= byte_in;
                                ph          <= PH_ALO;
                            end
                            PH_ALO: begin
                                row_o[5:0] <= byte_in[7:2];
                                col_o      <= byte_in[1:0];
                                ph         <= PH_DATA;
                            end
                            PH_DATA: if (wr_ok) begin
                                data_o[col_o*8 +: 8] <= byte_in;
                                vld_o[col_o]         <= 1'b1;
                                col_o                <= col_o + 2'd1;
                            end
                            default: ;
                        endcase
                    end else if (bit_cnt == 4'd8) begin
                        bit_cnt <= 4'd9;
                    end
                end else if (scl_fall) begin
                    if (bit_cnt == 4'd8) begin
                        sda_pull <= ack_q;
                    end else if (bit_cnt == 4'd9) begin
                        sda_pull <= 1'b0;
                        bit_cnt  <= '0;
                    end
                end
            end
        end
    end

    // R9
    bus_quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull);

    // R2
    pull_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    // R5
    locked_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_slot && bit_cnt != 4'd0 && lock && !pwd) |-> !sda_pull);
endmodule

// File: rtl/i2c_wr_store.sv
// Byte memory with a four-lane row write, the timed write cycle counter
// and the next-address register.
// Assumes: commit pulses only while the counter is idle.
module i2c_wr_store
    import i2c_wr_pkg::*;
#(
    parameter int MEM_AW = 6,
    parameter int WCYC   = 500
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic [13:0]          row,
    input  logic [COL_W-1:0]     col,
    input  logic [ROW_LEN*8-1:0] data,
    input  logic [ROW_LEN-1:0]   vld,
    input  logic [MEM_AW-1:0]    peek_addr,
    output logic [7:0]           peek_data,
    output logic                 busy,
    output logic [15:0]          next_addr
);
    localparam int MEM_N = 1 << MEM_AW;
    localparam int CNT_W = $clog2(WCYC + 1);

    logic [7:0]       mem [MEM_N];
    logic [CNT_W-1:0] cnt;

    // row commit into memory, cycle timer load and pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_N; i++) mem[i] <= '0;
            cnt       <= '0;
            next_addr <= '0;
        end else if (commit) begin
            for (int i = 0; i < ROW_LEN; i++)
                if (vld[i]) mem[{row[MEM_AW-3:0], 2'(i)}] <= data[i*8 +: 8];
            cnt       <= CNT_W'(WCYC);
            next_addr <= {row, col - 2'd1} + 16'd1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy      = (cnt != '0);
    assign peek_data = mem[peek_addr];

    // R8
    commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);

    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(next_addr));
endmodule

// File: rtl/i2c_wr_target.sv
// I2C write target top: line synchroniser, byte engine and memory store.
// Assumes: SDA pin is open drain; sda_pull_o=1 drives it low.
module i2c_wr_target
    import i2c_wr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h53,
    parameter int         MEM_AW   = 6,
    parameter int         WCYC     = 500,
    parameter int         STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic              lock_i,
    input  logic              pwd_ok_i,
    output logic              busy_o,
    output logic [15:0]       next_addr_o,
    input  logic [MEM_AW-1:0] peek_addr_i,
    output logic [7:0]        peek_data_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic commit;
    logic [13:0]          row;
    logic [COL_W-1:0]     col;
    logic [ROW_LEN*8-1:0] data;
    logic [ROW_LEN-1:0]   vld;

    i2c_line_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    i2c_wr_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
        .busy(busy_o), .lock(lock_i), .pwd(pwd_ok_i), .sda_pull(sda_pull_o),
        .commit(commit), .row_o(row), .col_o(col), .data_o(data), .vld_o(vld)
    );

    i2c_wr_store #(.MEM_AW(MEM_AW), .WCYC(WCYC)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .row(row), .col(col),
        .data(data), .vld(vld), .peek_addr(peek_addr_i), .peek_data(peek_data_o),
        .busy(busy_o), .next_addr(next_addr_o)
    );
endmodule

// File: tb/i2c_wr_target_test.sv
module i2c_wr_target_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [6:0] DEV  = 7'h53;
    localparam int         AW   = 6;
    localparam int         WCYC = 500;
    localparam int         Q    = 8;

    typedef struct packed {
        logic        lk;
        logic        pw;
        logic [15:0] a;
        logic [2:0]  n;
        logic [39:0] d;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 16'h0004, 3'd1, 40'h00000000A1},
        '{1'b0, 1'b0, 16'h0010, 3'd4, 40'h0044332211},
        '{1'b0, 1'b0, 16'h0022, 3'd3, 40'h0000C3C2C1},
        '{1'b1, 1'b0, 16'h0008, 3'd2, 40'h000000BEEF},
        '{1'b1, 1'b1, 16'h0009, 3'd2, 40'h0000005A6B},
        '{1'b0, 1'b0, 16'h1235, 3'd5, 40'h5544332211},
        '{1'b0, 1'b0, 16'h003F, 3'd1, 40'h00000000E7},
        '{1'b0, 1'b1, 16'h0000, 3'd2, 40'h0000009988}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic lock = 1'b0;
    logic pwd = 1'b0;
    logic [AW-1:0] peek_addr = '0;
    logic sda_pull, busy;
    logic [15:0] next_addr;
    logic [7:0] peek_data;
    logic sda_line;

    int total = 0;
    int bad = 0;
    logic [7:0] mdl [64];
    logic [15:0] mnext = 16'h0;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    i2c_wr_target #(.DEV_ADDR(DEV), .MEM_AW(AW), .WCYC(WCYC)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .lock_i(lock), .pwd_ok_i(pwd), .busy_o(busy),
        .next_addr_o(next_addr), .peek_addr_i(peek_addr), .peek_data_o(peek_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1;
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        acked = ~sda_line;
        wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic txn(input logic [7:0] sel, input logic [15:0] a, input int n,
                       input logic [39:0] d, output logic sack,
                       output logic [1:0] aack, output logic [4:0] dack);
        logic k;
        aack = '0; dack = '0;
        bus_start();
        send_byte(sel, sack);
        if (sack) begin
            send_byte(a[15:8], k); aack[1] = k;
            send_byte(a[7:0], k);  aack[0] = k;
            for (int i = 0; i < n; i++) begin
                send_byte(d[8*i +: 8], k); dack[i] = k;
            end
        end
        bus_stop();
    endtask

    function automatic int busy_len();
        return 0;
    endfunction

    task automatic count_busy(output int c);
        c = 0;
        for (int i = 0; i < WCYC + 40; i++) begin
            @(negedge clk);
            if (busy) c++;
        end
        wq(Q);
    endtask

    task automatic mem_cmp(input string tag);
        int mism = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            peek_addr = AW'(i);
            #1;
            if (peek_data !== mdl[i]) mism++;
        end
        @(negedge clk);
        chk(tag, mism, 0);
    endtask

    task automatic model_apply(input logic [15:0] a, input int n, input logic [39:0] d);
        logic [1:0] col = a[1:0];
        for (int i = 0; i < n; i++) begin
            mdl[{a[5:2], col}] = d[8*i +: 8];
            col = col + 2'd1;
        end
        mnext = {a[15:2], col - 2'd1} + 16'd1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic sack;
        logic [1:0] aack;
        logic [4:0] dack;
        logic k;
        int c;
        bit commit_exp;

        for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
        wq(5);
        rst_n = 1'b1;
        wq(5);

        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 next_addr", next_addr, 0);
        mem_cmp("R1 memory zero");

        // table of vectors
        for (int v = 0; v < 8; v++) begin
            lock = VECS[v].lk;
            pwd  = VECS[v].pw;
            wq(Q);
            txn({DEV, 1'b0}, VECS[v].a, int'(VECS[v].n), VECS[v].d, sack, aack, dack);
            count_busy(c);
            commit_exp = !(VECS[v].lk && !VECS[v].pw);
            chk("R2 select ack", sack, 1);
            chk("R3 address acks", aack, 2'b11);
            if (commit_exp) begin
                chk("R4 data acks", dack, (5'b11111 >> (5 - VECS[v].n)));
                model_apply(VECS[v].a, int'(VECS[v].n), VECS[v].d);
                chk("R8 busy length", c, WCYC);
            end else begin
                chk("R5 data noacks", dack, 0);
                chk("R5 no write cycle", c, 0);
            end
            mem_cmp("R6 memory after vector");
            chk("R10 next_addr", next_addr, mnext);
        end
        lock = 1'b0;
        pwd  = 1'b0;

        // R2: wrong select code and read direction are refused
        txn({7'h52, 1'b0}, 16'h0030, 1, 40'h11, sack, aack, dack);
        count_busy(c);
        chk("R2 wrong select noack", sack, 0);
        chk("R2 wrong select no cycle", c, 0);
        txn({DEV, 1'b1}, 16'h0030, 1, 40'h11, sack, aack, dack);
        count_busy(c);
        chk("R2 read bit noack", sack, 0);
        chk("R2 read bit no cycle", c, 0);
        mem_cmp("R2 memory unchanged");

        // R7: stop right after the address bytes commits nothing
        txn({DEV, 1'b0}, 16'h0018, 0, 40'h0, sack, aack, dack);
        count_busy(c);
        chk("R7 stop after address no cycle", c, 0);

        // R7: stop in the middle of a byte discards staged data
        bus_start();
        send_byte({DEV, 1'b0}, k);
        send_byte(8'h00, k);
        send_byte(8'h18, k);
        send_byte(8'h5C, k);
        chk("R4 staged byte acked", k, 1);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_stop();
        count_busy(c);
        chk("R7 mid-byte stop no cycle", c, 0);
        mem_cmp("R7 memory unchanged after mid-byte stop");

        // R9: traffic during the write cycle is ignored
        txn({DEV, 1'b0}, 16'h0030, 1, 40'h77, sack, aack, dack);
        model_apply(16'h0030, 1, 40'h77);
        bus_start();
        send_byte({DEV, 1'b0}, k);
        chk("R9 select ignored while busy", k, 0);
        send_byte(8'h00, k);
        send_byte(8'h2C, k);
        send_byte(8'hEE, k);
        bus_stop();
        count_busy(c);
        chk("R9 no second cycle", c, 0);
        mem_cmp("R9 memory holds only first write");
        chk("R10 next_addr after busy test", next_addr, mnext);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule